// File: doc/BRIEF.md
# Serial Flash Read Command Engine

This block is the slave side of a small serial NOR flash that answers read-type commands over a four-wire serial link. Chip-select is active low. The serial clock may idle low or high (SPI modes 0 and 3). The block takes an 8-bit opcode and then a 24-bit address, MSB first, from the serial input. It then streams bytes from an internal byte array onto the serial output, MSB first, and keeps going until chip-select is released. It serves three commands: a plain read, a fast read that discards one byte of clocks before the data, and an identification read that returns a fixed manufacturer or device code.

The four link pins are sampled by a free-running system clock and passed through synchronizers. SCK edges are found from the synchronized level. The serial output comes out as a data bit with an enable: enable low stands for high impedance. The array is a parameterized register file. A write port fills it while chip-select is idle; in the testbench this port does the preload. Programming, erasing and status registers are not part of this block.

Top module: `spi_flash_reader`

## Requirements
- R1: After reset, and whenever chip-select is high, `so_oe` is 0.
- R2: Opcode 03h followed by a 24-bit address, MSB first, streams array bytes MSB first from that address. The first data bit is driven after the SCK falling edge that follows the last address bit. SI is taken on SCK rising edges, and SO changes only after falling edges.
- R3: Opcode 0Bh behaves like 03h but skips 8 SCK clocks after the address before the first data bit. The SI value during those 8 clocks has no effect on the data.
- R4: While chip-select stays low the stream has no length limit. The byte address advances by one after every 8 data bits.
- R5: Only the low ADDR_W address bits select a byte. After byte 2^ADDR_W-1 the stream continues at byte 0.
- R6: `so_oe` stays 0 during the opcode, address and dummy phases.
- R7: Raising chip-select at any bit position ends the command. The next command, after chip-select falls again, is decoded from its first bit.
- R8: Opcode 90h with a 24-bit address returns MFR_CODE (default 5Ah) when address bit 0 is 0 and DEV_CODE (43h) when it is 1. The same byte repeats until chip-select rises.
- R9: Any other opcode keeps `so_oe` at 0 for the rest of that chip-select period.
- R10: All commands work both with SCK idling low (mode 0) and with SCK idling high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the link |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |
| load_en | input | 1 | Array write strobe for preload |
| load_addr | input | ADDR_W | Array write byte address |
| load_data | input | 8 | Array write data |

## Verification
Two events can land on the same SCK falling edge: the byte-boundary pointer increment and the wrap from the top array byte to byte 0. The bench triggers this by starting a read at byte 2^ADDR_W-2, with high address bits set that must be ignored. It then checks that the byte sequence runs through the top two bytes and continues at bytes 0 and 1. The same pointer step is also checked by a clocked property.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_IDENT = 8'h90;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_OUT,
    ST_DEAD
  } sfr_state_e;

  typedef enum logic [1:0] {
    K_READ,
    K_FAST,
    K_IDENT
  } sfr_kind_e;

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= RST_VAL[g];
        sync_q[g] <= RST_VAL[g];
      end else begin
        meta_q[g] <= d_in[g];
        sync_q[g] <= meta_q[g];
      end
    end
  end

  assign d_out = sync_q;

endmodule

// File: rtl/sfr_store.sv
module sfr_store #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cell_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = cell_q[rd_addr];

endmodule

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
  import sfr_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] MFR_CODE = 8'h5A,
  parameter logic [7:0] DEV_CODE = 8'h43
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_idle,
  input  logic              sck_lvl,
  input  logic              si_bit,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              so_bit,
  output logic              so_en
);

  localparam int         CNT_W   = 5;
  localparam logic [4:0] OP_LAST = 5'd7;
  localparam logic [4:0] AD_LAST = 5'd23;
  localparam logic [4:0] DM_LAST = 5'd7;

  sfr_state_e        state_q, state_d;
  sfr_kind_e         kind_q, kind_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [6:0]        op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [2:0]        bit_q, bit_d;
  logic              so_q, so_d;
  logic              oe_q, oe_d;
  logic              sck_prev_q;

  logic              sck_rise;
  logic              sck_fall;
  logic [7:0]        op_full;
  logic [ADDR_W-1:0] addr_full;
  logic [7:0]        out_byte;

  assign sck_rise  = sck_lvl & ~sck_prev_q;
  assign sck_fall  = ~sck_lvl & sck_prev_q;
  assign op_full   = {op_q, si_bit};
  assign addr_full = {addr_q[ADDR_W-2:0], si_bit};
  assign out_byte  = (kind_q == K_IDENT) ? (ptr_q[0] ? DEV_CODE : MFR_CODE) : rd_data;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    addr_d  = addr_q;
    ptr_d   = ptr_q;
    bit_d   = bit_q;
    so_d    = so_q;
    oe_d    = oe_q;
    if (cs_idle) begin
      state_d = ST_CMD;
      cnt_d   = '0;
      so_d    = 1'b0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_CMD: begin
          if (sck_rise) begin
            op_d  = op_full[6:0];
            cnt_d = cnt_q + 5'd1;
            if (cnt_q == OP_LAST) begin
              cnt_d = '0;
              if (op_full == OP_READ) begin
                kind_d  = K_READ;
                state_d = ST_ADDR;
              end else if (op_full == OP_FAST) begin
                kind_d  = K_FAST;
                state_d = ST_ADDR;
              end else if (op_full == OP_IDENT) begin
                kind_d  = K_IDENT;
                state_d = ST_ADDR;
              end else begin
                state_d = ST_DEAD;
              end
            end
          end
        end
        ST_ADDR: begin
          if (sck_rise) begin
            addr_d = addr_full;
            cnt_d  = cnt_q + 5'd1;
            if (cnt_q == AD_LAST) begin
              cnt_d   = '0;
              ptr_d   = addr_full;
              bit_d   = 3'd7;
              state_d = (kind_q == K_FAST) ? ST_DUMMY : ST_OUT;
            end
          end
        end
        ST_DUMMY: begin
          if (sck_rise) begin
            cnt_d = cnt_q + 5'd1;
            if (cnt_q == DM_LAST) begin
              cnt_d   = '0;
              state_d = ST_OUT;
            end
          end
        end
        ST_OUT: begin
          if (sck_fall) begin
            so_d  = out_byte[bit_q];
            oe_d  = 1'b1;
            bit_d = bit_q - 3'd1;
            if ((bit_q == 3'd0) && (kind_q != K_IDENT)) begin
              ptr_d = ptr_q + 1'b1;
            end
          end
        end
        default: begin
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_CMD;
      kind_q     <= K_READ;
      cnt_q      <= '0;
      op_q       <= '0;
      addr_q     <= '0;
      ptr_q      <= '0;
      bit_q      <= 3'd7;
      so_q       <= 1'b0;
      oe_q       <= 1'b0;
      sck_prev_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      kind_q     <= kind_d;
      cnt_q      <= cnt_d;
      op_q       <= op_d;
      addr_q     <= addr_d;
      ptr_q      <= ptr_d;
      bit_q      <= bit_d;
      so_q       <= so_d;
      oe_q       <= oe_d;
      sck_prev_q <= sck_lvl;
    end
  end

  assign rd_addr = ptr_q;
  assign so_bit  = so_q;
  assign so_en   = oe_q;

  // R6: no drive outside the data phase
  a_r6_quiet_header: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_OUT) |-> !oe_q);

  // R2: output bit moves only on an SCK falling edge
  a_r2_so_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !cs_idle) |=> ($stable(so_q) && $stable(oe_q)));

  // R7: released chip-select restarts decoding
  a_r7_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (state_q == ST_CMD && cnt_q == '0 && !oe_q));

  // R9: unknown opcode stays silent until release
  a_r9_dead_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEAD && !cs_idle) |=> (state_q == ST_DEAD && !oe_q));

  // R4, R5: pointer steps by one (mod array size) at byte end
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_idle && state_q == ST_OUT && sck_fall && bit_q == 3'd0 && kind_q != K_IDENT)
      |=> (ptr_q == ADDR_W'($past(ptr_q) + 1'b1)));

endmodule

// File: rtl/spi_flash_reader.sv
module spi_flash_reader #(
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] MFR_CODE = 8'h5A,
  parameter logic [7:0] DEV_CODE = 8'h43
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [7:0]        load_data
);

  logic       rst_meta_q;
  logic       rst_sync_q;
  logic [2:0] pins_s;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sfr_sync #(
    .WIDTH   (3),
    .RST_VAL (3'b100)
  ) i_pins (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d_in  ({cs_n, sck, si}),
    .d_out (pins_s)
  );

  sfr_store #(
    .ADDR_W (ADDR_W)
  ) i_store (
    .clk     (clk),
    .wr_en   (load_en),
    .wr_addr (load_addr),
    .wr_data (load_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  sfr_ctrl #(
    .ADDR_W   (ADDR_W),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
  ) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .cs_idle (pins_s[2]),
    .sck_lvl (pins_s[1]),
    .si_bit  (pins_s[0]),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .so_bit  (so),
    .so_en   (so_oe)
  );

endmodule

// File: tb/test_spi_flash_reader.sv
module test_spi_flash_reader;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int AW         = 8;
  localparam logic [7:0] MFR = 8'h5A;
  localparam logic [7:0] DEV = 8'h43;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n;
  logic sck;
  logic si;
  logic so;
  logic so_oe;
  logic load_en;
  logic [AW-1:0] load_addr;
  logic [7:0] load_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_flash_reader #(.ADDR_W(AW)) i_spi_flash_reader (
    .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sck (sck), .si (si),
    .so (so), .so_oe (so_oe),
    .load_en (load_en), .load_addr (load_addr), .load_data (load_data)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic cs_begin(bit m3);
    sck = m3;
    wait_clk(HALF);
    cs_n = 1'b0;
    wait_clk(HALF);
    if (m3) begin
      sck = 1'b0;
    end
  endtask

  task automatic cs_end(bit m3);
    wait_clk(HALF);
    if (m3) begin
      sck = 1'b1;
      wait_clk(HALF);
    end
    cs_n = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic xfer(logic d, output logic q, output logic e);
    si = d;
    wait_clk(HALF);
    @(negedge clk);
    q = so;
    e = so_oe;
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic send(logic [31:0] v, int n, inout int oe_hits);
    logic q, e;
    for (int i = n - 1; i >= 0; i--) begin
      xfer(v[i], q, e);
      if (e) oe_hits++;
    end
  endtask

  task automatic recv(output logic [7:0] b, output int oe_low);
    logic q, e;
    oe_low = 0;
    for (int i = 7; i >= 0; i--) begin
      xfer(1'b0, q, e);
      b[i] = q;
      if (!e) oe_low++;
    end
  endtask

  task automatic idle_check(string req);
    @(negedge clk);
    check(so_oe == 1'b0, req, so_oe, 0);
  endtask

  // generic read-type command with per-byte comparison
  task automatic run_cmd(bit m3, logic [7:0] op, logic [23:0] addr,
                         bit dummy, logic [7:0] dval, int nbytes, string req);
    int hits = 0;
    int low;
    logic [7:0] b, exp;
    cs_begin(m3);
    send({24'd0, op}, 8, hits);
    send({8'd0, addr}, 24, hits);
    if (dummy) send({24'd0, dval}, 8, hits);
    check(hits == 0, {req, " R6 header quiet"}, hits, 0);
    for (int k = 0; k < nbytes; k++) begin
      recv(b, low);
      if (op == 8'h90) exp = addr[0] ? DEV : MFR;
      else exp = pat((int'(addr[AW-1:0]) + k) & 255);
      check(b == exp && low == 0, req, b, exp);
    end
    cs_end(m3);
    idle_check({req, " R1 idle after release"});
  endtask

  task automatic t_reset;
    idle_check("R1 reset");
  endtask

  task automatic t_read;
    run_cmd(1'b0, 8'h03, 24'h000010, 1'b0, 8'h00, 5, "R2 R4 read mode0");
    run_cmd(1'b1, 8'h03, 24'h000081, 1'b0, 8'h00, 3, "R2 R10 read mode3");
  endtask

  task automatic t_fast;
    run_cmd(1'b0, 8'h0B, 24'h000040, 1'b1, 8'hFF, 3, "R3 fast dummy ff");
    run_cmd(1'b1, 8'h0B, 24'h000040, 1'b1, 8'h00, 3, "R3 R10 fast dummy 00 mode3");
  endtask

  task automatic t_wrap;
    run_cmd(1'b0, 8'h03, 24'h3AB0FE, 1'b0, 8'h00, 4, "R5 wrap high bits ignored");
  endtask

  task automatic t_abort;
    int hits = 0;
    int low;
    logic [7:0] b;
    cs_begin(1'b0);
    send(32'h03, 8, hits);
    send(32'h0, 12, hits);
    cs_end(1'b0);
    idle_check("R7 abort in address");
    cs_begin(1'b0);
    send(32'h03, 8, hits);
    send(32'h20, 24, hits);
    recv(b, low);
    send(32'h0, 3, hits);
    cs_end(1'b0);
    idle_check("R7 abort in data");
    check(b == pat(32'h20), "R7 first byte before abort", b, pat(32'h20));
    run_cmd(1'b0, 8'h03, 24'h000033, 1'b0, 8'h00, 2, "R7 clean restart");
  endtask

  task automatic t_ident;
    run_cmd(1'b0, 8'h90, 24'h000000, 1'b0, 8'h00, 3, "R8 manufacturer code");
    run_cmd(1'b1, 8'h90, 24'h000001, 1'b0, 8'h00, 3, "R8 R10 device code");
  endtask

  task automatic t_bad;
    int hits = 0;
    cs_begin(1'b0);
    send(32'h55, 8, hits);
    send(32'hFFFFFFFF, 32, hits);
    check(hits == 0, "R9 unknown opcode silent", hits, 0);
    cs_end(1'b0);
    run_cmd(1'b0, 8'h03, 24'h000007, 1'b0, 8'h00, 1, "R9 read after unknown");
  endtask

  initial begin
    rst_n = 1'b0;
    cs_n = 1'b1;
    sck = 1'b0;
    si = 1'b0;
    load_en = 1'b0;
    load_addr = '0;
    load_data = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    for (int a = 0; a < (1 << AW); a++) begin
      @(negedge clk);
      load_en = 1'b1;
      load_addr = AW'(a);
      load_data = pat(a);
    end
    @(negedge clk);
    load_en = 1'b0;
    wait_clk(4);
    t_read();
    t_fast();
    t_wrap();
    t_abort();
    t_ident();
    t_bad();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_clk(200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule